// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block turns single host requests into correctly sequenced strobe patterns for an external 2K x 8 asynchronous static RAM. The host presents an address, a direction flag and a write byte on a valid/ready handshake. The controller then walks the memory through four phases: an address setup phase with every strobe inactive, a strobe phase (read or write), a recovery phase, and a return to idle. The length of each phase is a module parameter in whole clock cycles. Each parameter is obtained by rounding the memory's nanosecond limit up to the clock period, with a minimum of one cycle.

The memory strobes are all active low. Chip select high means standby, and the memory I/O is high impedance. Chip select low with output enable low and write enable high is a read, and the memory drives data. Chip select low with write enable low is a write, whatever output enable is doing. A write is committed when chip select or write enable rises, whichever comes first. The controller moves the address only while chip select is high. It pulls chip select and write enable low in the same cycle, so the memory never turns its outputs on at the start of a write.

A parameter decides whether output enable stays low during writes. When it does, the write pulse is stretched to cover the output turn-off time plus the data setup time. In that mode the data drivers stay off until the memory has released the bus.

Top module: `sram_ctl`

## Requirements
- R1: After reset, and in every cycle where `req_ready` is high, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are all 1 and `mem_dq_oe` is 0. `req_ready` is high only while the controller is idle.
- R2: An accepted request places its address on `mem_addr` in the following cycle. All strobes then stay high for exactly `T_AS` cycles. `mem_addr` does not change while `mem_cs_n` is low.
- R3: A read holds `mem_cs_n` and `mem_oe_n` low, and `mem_we_n` high, for exactly `T_RD` cycles. The byte on `mem_dq_in` in the last of those cycles appears on `rd_data`, and `rd_valid` is high for exactly one cycle.
- R4: A write pulls `mem_cs_n` and `mem_we_n` low in the same cycle. When `WR_OE_LOW` = 0, both stay low for max(`T_WP`, `T_DW`) cycles and `mem_oe_n` stays 1 throughout.
- R5: When `WR_OE_LOW` = 1, `mem_oe_n` is low for the whole write and `mem_we_n` stays low for max(`T_WP`, `T_WHZ` + `T_DW`) cycles. `mem_dq_oe` stays 0 during the first `T_WHZ` cycles of the write.
- R6: The write byte is driven on `mem_dq_out`, with `mem_dq_oe` = 1, from the drive start of the write until `T_DH` cycles after `mem_we_n` rises. The drive start is the first write cycle when `WR_OE_LOW` = 0, and cycle index `T_WHZ` when it is 1. The controller never drives while the memory is in a read state.
- R7: After every read or write phase, all strobes stay high for exactly `T_REC` cycles before `req_ready` returns.
- R8: `rd_valid` pulses only for read requests, never for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write byte |
| rd_valid | output | 1 | One-cycle pulse marking read data |
| rd_data | output | DW | Captured read byte |
| mem_addr | output | AW | Memory address bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DW | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enables the data drivers toward the memory |
| mem_dq_in | input | DW | Data returned by the memory |

## Verification
The bench targets exact phase lengths. A counter off by one would give a setup phase, strobe phase or recovery phase one cycle too short, and the bench counts each of them. In the mode where output enable stays low, a design that drove data too early would fight the memory's own output drivers. A design that did not stretch the write pulse would show too few write enable cycles. A bench memory model commits writes only on the rising edge of the strobe. It reports any address change while selected and any overlap between its own drive and the controller's, so a wrong hold or release timing appears as corrupted read-back or a model violation.

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int AW        = 11,
  parameter int DW        = 8,
  parameter int T_AS      = 1,
  parameter int T_RD      = 2,
  parameter int T_WP      = 1,
  parameter int T_DW      = 1,
  parameter int T_WHZ     = 1,
  parameter int T_DH      = 0,
  parameter int T_REC     = 1,
  parameter int WR_OE_LOW = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int WE_BASE  = (T_WP > T_DW) ? T_WP : T_DW;
  localparam int WE_OEL   = T_WHZ + T_DW;
  localparam int WE_LEN   = (WR_OE_LOW != 0 && WE_OEL > WE_BASE) ? WE_OEL : WE_BASE;
  localparam int DRV_AT   = (WR_OE_LOW != 0) ? T_WHZ : 0;
  localparam int SUM_LEN  = T_AS + T_RD + WE_LEN + T_REC + T_DH + 2;
  localparam int CW       = $clog2(SUM_LEN);

  localparam logic [CW-1:0] LAST_AS  = CW'(T_AS - 1);
  localparam logic [CW-1:0] LAST_RD  = CW'(T_RD - 1);
  localparam logic [CW-1:0] LAST_WE  = CW'(WE_LEN - 1);
  localparam logic [CW-1:0] LAST_REC = CW'(T_REC - 1);
  localparam logic [CW-1:0] DRV_PRE  = CW'(DRV_AT - 1);
  localparam logic [CW-1:0] DH_LAST  = CW'(T_DH - 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_READ, S_WRITE, S_RECOV} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          wr_q;

  assign req_ready = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      wr_q       <= 1'b0;
      mem_addr   <= '0;
      mem_cs_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            mem_addr   <= req_addr;
            wr_q       <= req_write;
            mem_dq_out <= req_wdata;
            cnt        <= '0;
            state      <= S_SETUP;
          end
        end
        S_SETUP: begin
          if (cnt == LAST_AS) begin
            cnt      <= '0;
            mem_cs_n <= 1'b0;
            if (wr_q) begin
              mem_we_n  <= 1'b0;
              mem_oe_n  <= (WR_OE_LOW == 0);
              mem_dq_oe <= (DRV_AT == 0);
              state     <= S_WRITE;
            end else begin
              mem_oe_n <= 1'b0;
              state    <= S_READ;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_READ: begin
          if (cnt == LAST_RD) begin
            rd_data  <= mem_dq_in;
            rd_valid <= 1'b1;
            mem_cs_n <= 1'b1;
            mem_oe_n <= 1'b1;
            cnt      <= '0;
            state    <= S_RECOV;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WRITE: begin
          if (DRV_AT > 0 && cnt == DRV_PRE) mem_dq_oe <= 1'b1;
          if (cnt == LAST_WE) begin
            mem_cs_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= (T_DH > 0);
            cnt       <= '0;
            state     <= S_RECOV;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RECOV: begin
          if (T_DH > 0 && cnt == DH_LAST) mem_dq_oe <= 1'b0;
          if (cnt == LAST_REC) begin
            mem_dq_oe <= 1'b0;
            cnt       <= '0;
            state     <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int AW        = 11,
  parameter int WR_OE_LOW = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rd_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

  p_rv_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_we_with_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $fell(mem_cs_n));

  p_no_fight_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n || !mem_we_n || mem_cs_n));

  p_rv_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(!mem_cs_n) && $past(!mem_oe_n) && $past(mem_we_n)));

  generate
    if (WR_OE_LOW == 0) begin : g_oe_high
      p_write_oe_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);
    end else begin : g_oe_low
      p_write_oe_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_oe_n);
    end
  endgenerate

endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW), .WR_OE_LOW(WR_OE_LOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctl_bench.sv
module sram_model (
  input  logic        clk,
  input  logic [10:0] addr,
  input  logic        cs_n,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic [7:0]  dq_out,
  input  logic        dq_oe,
  output logic [7:0]  din,
  output int          viol
);
  logic [7:0]  mem [2048];
  logic        prev_sel, prev_wact, have;
  logic [10:0] prev_addr;
  logic [7:0]  pend;

  assign din = (!cs_n && !oe_n && we_n) ? mem[addr] : 8'h00;

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
    viol = 0; prev_sel = 0; prev_wact = 0; have = 0; prev_addr = '0; pend = '0;
  end

  always @(negedge clk) begin
    if (prev_sel && !cs_n && addr != prev_addr) viol++;
    if (dq_oe && !cs_n && !oe_n && we_n) viol++;
    if (!cs_n && !we_n && dq_oe) begin pend = dq_out; have = 1; end
    if (prev_wact && !(!cs_n && !we_n)) begin
      if (have) mem[prev_addr] = pend; else viol++;
      have = 0;
    end
    prev_wact = !cs_n && !we_n;
    prev_sel  = !cs_n;
    prev_addr = addr;
  end
endmodule

module sram_ctl_bench;
  localparam int P_AS = 2, P_RD = 3, P_WP = 2, P_DW = 1, P_WHZ = 2, P_DH = 1, P_REC = 2;

  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic        va = 0, vb = 0, wr_i = 0;
  logic [10:0] addr_i = '0;
  logic [7:0]  wd_i = '0;

  logic        rdy [2];
  logic        rv [2];
  logic [7:0]  rdat [2];
  logic [10:0] maddr [2];
  logic        cs [2], oe [2], we [2], dqoe [2];
  logic [7:0]  dqo [2], din [2];
  int          mviol [2];

  sram_ctl #(.T_AS(P_AS), .T_RD(P_RD), .T_WP(P_WP), .T_DW(P_DW), .T_WHZ(P_WHZ),
             .T_DH(P_DH), .T_REC(P_REC), .WR_OE_LOW(0)) u_sram_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(va), .req_ready(rdy[0]), .req_write(wr_i),
    .req_addr(addr_i), .req_wdata(wd_i), .rd_valid(rv[0]), .rd_data(rdat[0]),
    .mem_addr(maddr[0]), .mem_cs_n(cs[0]), .mem_oe_n(oe[0]), .mem_we_n(we[0]),
    .mem_dq_out(dqo[0]), .mem_dq_oe(dqoe[0]), .mem_dq_in(din[0]));

  sram_ctl #(.T_AS(P_AS), .T_RD(P_RD), .T_WP(P_WP), .T_DW(P_DW), .T_WHZ(P_WHZ),
             .T_DH(P_DH), .T_REC(P_REC), .WR_OE_LOW(1)) u_sram_ctl_oel (
    .clk(clk), .rst_n(rst_n), .req_valid(vb), .req_ready(rdy[1]), .req_write(wr_i),
    .req_addr(addr_i), .req_wdata(wd_i), .rd_valid(rv[1]), .rd_data(rdat[1]),
    .mem_addr(maddr[1]), .mem_cs_n(cs[1]), .mem_oe_n(oe[1]), .mem_we_n(we[1]),
    .mem_dq_out(dqo[1]), .mem_dq_oe(dqoe[1]), .mem_dq_in(din[1]));

  sram_model u_mem_a (.clk(clk), .addr(maddr[0]), .cs_n(cs[0]), .oe_n(oe[0]), .we_n(we[0]),
                      .dq_out(dqo[0]), .dq_oe(dqoe[0]), .din(din[0]), .viol(mviol[0]));
  sram_model u_mem_b (.clk(clk), .addr(maddr[1]), .cs_n(cs[1]), .oe_n(oe[1]), .we_n(we[1]),
                      .dq_out(dqo[1]), .dq_oe(dqoe[1]), .din(din[1]), .viol(mviol[1]));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  typedef struct {
    int st, csc, wec, oec, oew, drv, early, rvc, rec, addr_ok;
    logic [7:0] rd;
  } obs_t;

  task automatic xact(input int s, input logic w, input logic [10:0] a,
                      input logic [7:0] d, output obs_t o);
    int guard = 0;
    int widx = 0;
    bit seen = 0;
    o = '{default: 0};
    o.addr_ok = 1;
    @(negedge clk);
    while (!rdy[s]) @(negedge clk);
    addr_i = a; wr_i = w; wd_i = d;
    if (s == 0) va = 1; else vb = 1;
    @(negedge clk);
    va = 0; vb = 0;
    while (!rdy[s] && guard < 500) begin
      if (maddr[s] != a) o.addr_ok = 0;
      if (!cs[s]) begin
        seen = 1; o.csc++;
        if (!we[s]) begin
          if (dqoe[s] && widx < P_WHZ) o.early++;
          if (!oe[s]) o.oew++;
          o.wec++; widx++;
        end
        if (!oe[s]) o.oec++;
      end else if (!seen) o.st++;
      else o.rec++;
      if (dqoe[s]) o.drv++;
      if (rv[s]) begin o.rvc++; o.rd = rdat[s]; end
      @(negedge clk);
      guard++;
    end
    if (guard >= 500) chk("R7 transaction completes", 0, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset ready", rdy[0], 1);
    chk("R1 reset cs_n", cs[0], 1);
    chk("R1 reset oe_n", oe[0], 1);
    chk("R1 reset we_n", we[0], 1);
    chk("R1 reset dq_oe", dqoe[0], 0);
    chk("R1 reset rd_valid", rv[0], 0);
  endtask

  task automatic t_write_plain(input logic [10:0] a, input logic [7:0] d);
    obs_t o;
    xact(0, 1'b1, a, d, o);
    chk("R2 addr setup cycles", o.st, P_AS);
    chk("R2 address held", o.addr_ok, 1);
    chk("R4 we_n low cycles", o.wec, P_WP);
    chk("R4 cs_n low equals we_n low", o.csc, o.wec);
    chk("R4 oe_n high during write", o.oew, 0);
    chk("R6 drive cycles incl hold", o.drv, P_WP + P_DH);
    chk("R7 recovery cycles", o.rec, P_REC);
    chk("R8 no rd_valid on write", o.rvc, 0);
  endtask

  task automatic t_read_plain(input logic [10:0] a, input logic [7:0] exp);
    obs_t o;
    xact(0, 1'b0, a, 8'h00, o);
    chk("R2 addr setup cycles", o.st, P_AS);
    chk("R3 cs_n low cycles", o.csc, P_RD);
    chk("R3 oe_n low cycles", o.oec, P_RD);
    chk("R3 we_n stays high", o.wec, 0);
    chk("R3 single rd_valid", o.rvc, 1);
    chk("R3 read data", o.rd, exp);
    chk("R6 no drive on read", o.drv, 0);
    chk("R7 recovery cycles", o.rec, P_REC);
  endtask

  task automatic t_write_oel(input logic [10:0] a, input logic [7:0] d);
    obs_t o;
    xact(1, 1'b1, a, d, o);
    chk("R5 stretched we_n low", o.wec, P_WHZ + P_DW);
    chk("R5 oe_n low through write", o.oew, P_WHZ + P_DW);
    chk("R5 no early drive", o.early, 0);
    chk("R6 drive cycles oe-low mode", o.drv, P_DW + P_DH);
    chk("R8 no rd_valid on write", o.rvc, 0);
  endtask

  task automatic t_read_oel(input logic [10:0] a, input logic [7:0] exp);
    obs_t o;
    xact(1, 1'b0, a, 8'h00, o);
    chk("R3 read data oe-low mode", o.rd, exp);
    chk("R3 single rd_valid", o.rvc, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_write_plain(11'h000, 8'hA5);
    t_write_plain(11'h7FF, 8'h3C);
    t_write_plain(11'h2AA, 8'hFF);
    t_read_plain(11'h000, 8'hA5);
    t_read_plain(11'h7FF, 8'h3C);
    t_read_plain(11'h2AA, 8'hFF);
    t_read_plain(11'h155, 8'h00);
    t_write_plain(11'h000, 8'h5A);
    t_read_plain(11'h000, 8'h5A);
    t_write_oel(11'h123, 8'hC3);
    t_write_oel(11'h7FF, 8'h81);
    t_read_oel(11'h123, 8'hC3);
    t_read_oel(11'h7FF, 8'h81);
    @(negedge clk);
    chk("R2 model addr/commit violations A", mviol[0], 0);
    chk("R6 model contention violations B", mviol[1], 0);
    chk("R1 idle after run", rdy[0] && cs[0] && oe[0] && we[0] && !dqoe[0], 1);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) chk("R7 watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule